// File: doc/BRIEF.md
# Radio Operating Mode Auto-Sequencer

This block chooses the operating mode that a radio's mode hardware should use. Software programs a base mode. Software can also enable automatic switching. When switching is on, an edge on one selected status flag moves the output to a single programmed intermediate mode. A second selected event, either an edge on a flag or a timeout pulse, moves the output back to the base mode. The status flags are FIFO not empty, FIFO level reached, CRC good, payload ready, sync/address matched and packet sent. The timeout source and the mode hardware are outside the block.

The block detects edges by comparing each flag with its value from the previous clock cycle. The sequencer has two states, idle and intermediate. The output mode is registered only through this state bit. When an event occurs, the output changes in the cycle that follows the clock edge which sampled it.

Top module: `auto_mode_seq`

## Requirements
- R1: During reset and whenever the sequencer is idle, `mode_out` equals `base_mode`. Reset leaves the sequencer idle.
- R2: While idle, the sequencer enters the intermediate mode on the event chosen by `enter_sel`. The codes are: 1 = rising edge of `fifo_not_empty`, 2 = rising edge of `fifo_level`, 3 = rising edge of `crc_ok`, 4 = rising edge of `payload_ready`, 5 = rising edge of `sync_match`, 6 = rising edge of `packet_sent`, 7 = falling edge of `fifo_not_empty`.
- R3: While in the intermediate mode, the sequencer returns to idle on the event chosen by `exit_sel`. The codes are: 1 = falling edge of `fifo_not_empty`, 2 = `fifo_level` rising or `timeout`, 3 = `crc_ok` rising or `timeout`, 4 = `payload_ready` rising or `timeout`, 5 = `sync_match` rising or `timeout`, 6 = `packet_sent` rising, 7 = `timeout` alone. `timeout` counts in any cycle in which it is high.
- R4: While in the intermediate mode, `mode_out` equals `inter_mode` unchanged. The encodings are 0 sleep, 1 standby, 2 receive, 3 transmit.
- R5: If `enter_sel` or `exit_sel` is 0, automatic switching is off. The sequencer does not enter the intermediate mode, and if it is already in that mode it returns to idle at the next clock edge.
- R6: An edge is the difference between a flag's value at one clock edge and its value at the previous clock edge. The first clock edge after reset is released produces no edge, even for a flag that was already high.
- R7: While in the intermediate mode, enter events have no effect. Exit events have no effect while idle.
- R8: A `base_mode_wr` pulse sends the sequencer to idle at the next clock edge. This takes priority over any enter event.
- R9: When an event is seen at a clock edge, `mode_out` changes right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| base_mode | input | 2 | Base mode programmed by software |
| base_mode_wr | input | 1 | One-cycle pulse when software writes the base mode |
| enter_sel | input | 3 | Selects the enter event |
| exit_sel | input | 3 | Selects the exit event |
| inter_mode | input | 2 | Intermediate mode |
| fifo_not_empty | input | 1 | FIFO holds at least one entry |
| fifo_level | input | 1 | FIFO fill level reached its threshold |
| crc_ok | input | 1 | CRC check passed |
| payload_ready | input | 1 | Payload ready |
| sync_match | input | 1 | Sync word / address matched |
| packet_sent | input | 1 | Packet transmission finished |
| timeout | input | 1 | Timeout event |
| mode_out | output | 2 | Effective operating mode |

## Verification
The bench holds `fifo_not_empty` high through reset. A design that seeded its edge detector with zeros would see this as a rising edge and leave the base mode with no real event.

It also checks two ignored-event cases:
- Enter edges while the intermediate mode is active must be ignored. A design that re-armed on them would hold the mode.
- A timeout under exit code 1 or 6 must be ignored. A design that wrongly OR-ed the timeout in would drop out early.

The falling-edge codes (enter 7, exit 1) are exercised, so a polarity mix-up would show as a wrong mode. A base-mode write that arrives together with an enter edge, and clearing a select field while active, are checked to return to the base mode the next cycle.

// File: rtl/auto_mode_seq.sv
module auto_mode_seq #(
  parameter int MODE_W = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] base_mode,
  input  logic              base_mode_wr,
  input  logic [SEL_W-1:0]  enter_sel,
  input  logic [SEL_W-1:0]  exit_sel,
  input  logic [MODE_W-1:0] inter_mode,
  input  logic              fifo_not_empty,
  input  logic              fifo_level,
  input  logic              crc_ok,
  input  logic              payload_ready,
  input  logic              sync_match,
  input  logic              packet_sent,
  input  logic              timeout,
  output logic [MODE_W-1:0] mode_out
);

  localparam int NFLAG = 6;

  logic [NFLAG-1:0] flags, prev_q, rise, fall;
  logic primed_q, active_q;
  logic enter_hit, exit_hit, cfg_on;

  assign flags = {packet_sent, sync_match, payload_ready, crc_ok, fifo_level, fifo_not_empty};
  assign rise  = flags & ~prev_q & {NFLAG{primed_q}};
  assign fall  = ~flags & prev_q & {NFLAG{primed_q}};
  assign cfg_on = (enter_sel != '0) && (exit_sel != '0);

  always_comb begin
    case (enter_sel)
      3'd1:    enter_hit = rise[0];
      3'd2:    enter_hit = rise[1];
      3'd3:    enter_hit = rise[2];
      3'd4:    enter_hit = rise[3];
      3'd5:    enter_hit = rise[4];
      3'd6:    enter_hit = rise[5];
      3'd7:    enter_hit = fall[0];
      default: enter_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (exit_sel)
      3'd1:    exit_hit = fall[0];
      3'd2:    exit_hit = rise[1] | timeout;
      3'd3:    exit_hit = rise[2] | timeout;
      3'd4:    exit_hit = rise[3] | timeout;
      3'd5:    exit_hit = rise[4] | timeout;
      3'd6:    exit_hit = rise[5];
      3'd7:    exit_hit = timeout;
      default: exit_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      prev_q   <= flags;
      primed_q <= 1'b1;
      if (base_mode_wr || !cfg_on)
        active_q <= 1'b0;
      else if (!active_q && enter_hit)
        active_q <= 1'b1;
      else if (active_q && exit_hit)
        active_q <= 1'b0;
    end
  end

  assign mode_out = active_q ? inter_mode : base_mode;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !active_q); // R1
  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> !active_q); // R6
  AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && enter_hit && cfg_on && !base_mode_wr) |=> (mode_out == inter_mode)); // R2
  AST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && exit_hit && !base_mode_wr) |=> (mode_out == base_mode)); // R3
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on |=> (mode_out == base_mode)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !exit_hit && cfg_on && !base_mode_wr) |=> active_q); // R7
  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    base_mode_wr |=> (mode_out == base_mode)); // R8

endmodule

// File: tb/test_auto_mode_seq.sv
module test_auto_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] base_mode = 2'd1, inter_mode = 2'd2;
  logic base_mode_wr = 1'b0;
  logic [2:0] enter_sel = 3'd1, exit_sel = 3'd7;
  logic fne = 1'b1, flv = 1'b0, crc = 1'b0, prdy = 1'b0, sync = 1'b0, psent = 1'b0, tmo = 1'b0;
  logic [1:0] mode_out;

  int checks = 0, errors = 0;
  logic m_act = 1'b0, m_primed = 1'b0;
  logic [5:0] m_prev = '0;

  always #4 clk = ~clk;

  auto_mode_seq i_auto_mode_seq (
    .clk(clk), .rst_n(rst_n), .base_mode(base_mode), .base_mode_wr(base_mode_wr),
    .enter_sel(enter_sel), .exit_sel(exit_sel), .inter_mode(inter_mode),
    .fifo_not_empty(fne), .fifo_level(flv), .crc_ok(crc), .payload_ready(prdy),
    .sync_match(sync), .packet_sent(psent), .timeout(tmo), .mode_out(mode_out));

  function automatic logic up(input logic [5:0] cur, input logic [5:0] prv, input int i);
    return cur[i] && !prv[i];
  endfunction

  function automatic logic enter_ev(input logic [2:0] s, input logic [5:0] cur, input logic [5:0] prv);
    if (s == 3'd7) return !cur[0] && prv[0];
    if (s == 3'd0) return 1'b0;
    return up(cur, prv, int'(s) - 1);
  endfunction

  function automatic logic exit_ev(input logic [2:0] s, input logic [5:0] cur, input logic [5:0] prv, input logic t);
    case (s)
      3'd1: return !cur[0] && prv[0];
      3'd6: return up(cur, prv, 5);
      3'd7: return t;
      3'd0: return 1'b0;
      default: return t || up(cur, prv, int'(s) - 1);
    endcase
  endfunction

  function automatic logic [1:0] expected();
    return m_act ? inter_mode : base_mode;
  endfunction

  task automatic chk(input string tag, input logic [1:0] exp);
    checks++;
    if (mode_out !== exp) begin
      errors++;
      $display("FAIL %s mode_out=%0d expected=%0d at %0t", tag, mode_out, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic [5:0] cur;
    @(posedge clk);
    cur = {psent, sync, prdy, crc, flv, fne};
    if (!rst_n) begin
      m_act = 1'b0; m_primed = 1'b0; m_prev = '0;
    end else begin
      if (base_mode_wr || enter_sel == 3'd0 || exit_sel == 3'd0) m_act = 1'b0;
      else if (!m_act && m_primed && enter_ev(enter_sel, cur, m_prev)) m_act = 1'b1;
      else if (m_act && exit_ev(exit_sel, cur, m_prev, tmo)) m_act = 1'b0;
      m_prev = cur; m_primed = 1'b1;
    end
    @(negedge clk);
    chk(tag, expected());
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'd1);
    rst_n = 1'b1;
    step("R6 first"); chk("R6 high at reset no edge", 2'd1);
    step("R6 second"); chk("R6 still base", 2'd1);
    fne = 1'b0; step("R2 fall ignored"); chk("R2 fall under code 1", 2'd1);
    fne = 1'b1; step("R9 enter"); chk("R2 R4 R9 enter rx", 2'd2);
    fne = 1'b0; step("R7 a"); fne = 1'b1; step("R7 b"); chk("R7 enter edges ignored", 2'd2);
    tmo = 1'b1; step("R3 tmo"); chk("R3 timeout exit", 2'd1); tmo = 1'b0;
    enter_sel = 3'd4; exit_sel = 3'd2; inter_mode = 2'd3;
    step("R3 idle"); flv = 1'b1; step("R7 exit idle"); chk("R7 exit event while idle", 2'd1);
    prdy = 1'b1; step("R2 prdy"); chk("R2 R4 payload enter tx", 2'd3);
    flv = 1'b0; step("R3 hold"); flv = 1'b1; step("R3 flv"); chk("R3 level exit", 2'd1);
    enter_sel = 3'd7; exit_sel = 3'd6;
    fne = 1'b0; step("R2 fall"); chk("R2 falling enter", 2'd3);
    tmo = 1'b1; step("R3 tmo ignored"); chk("R3 timeout ignored by code 6", 2'd3); tmo = 1'b0;
    base_mode = 2'd0; base_mode_wr = 1'b1; step("R8 wr"); chk("R8 write returns idle", 2'd0);
    base_mode_wr = 1'b0; step("R8 after"); chk("R8 stays base", 2'd0);
    enter_sel = 3'd1; fne = 1'b1; base_mode_wr = 1'b1; step("R8 prio"); chk("R8 write beats enter", 2'd0);
    base_mode_wr = 1'b0;
    enter_sel = 3'd0; exit_sel = 3'd7; fne = 1'b0; step("R5 a"); fne = 1'b1; step("R5 b");
    chk("R5 enter code 0 no switch", 2'd0);
    enter_sel = 3'd1; fne = 1'b0; step("R5 c"); fne = 1'b1; step("R5 d"); chk("R5 active", 2'd3);
    exit_sel = 3'd0; step("R5 e"); chk("R5 exit code 0 forces idle", 2'd0);
    exit_sel = 3'd1; fne = 1'b0; step("R3 f"); fne = 1'b1; step("R3 g"); chk("R3 entered", 2'd3);
    fne = 1'b0; step("R3 h"); chk("R3 fifo empty exit", 2'd0);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) fne = ~fne;
      if ($urandom_range(0, 3) == 0) flv = ~flv;
      if ($urandom_range(0, 3) == 0) crc = ~crc;
      if ($urandom_range(0, 3) == 0) prdy = ~prdy;
      if ($urandom_range(0, 3) == 0) sync = ~sync;
      if ($urandom_range(0, 3) == 0) psent = ~psent;
      tmo = ($urandom_range(0, 9) == 0);
      base_mode_wr = ($urandom_range(0, 39) == 0);
      if (base_mode_wr) base_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 59) == 0) enter_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 59) == 0) exit_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) == 0) inter_mode = 2'($urandom_range(0, 3));
      if (n == 2000) begin
        rst_n = 1'b0; step("R1 mid reset"); rst_n = 1'b1;
      end else step("R2 R3 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule